// File: doc/BRIEF.md
# Three-Phase Complementary PWM with Dead-Time Insertion

This block drives three half-bridges from one shared triangle counter. For each phase it compares the counter against an active duty value to form a raw phase signal. From that raw signal it produces a positive (upper switch) output and a negative (lower switch) output. When dead-time insertion is on, every switch-over between the two outputs passes through a programmable number of clocks in which both outputs are inactive. As a result, the upper and lower switches are never driven together.

Software writes duty values into buffer registers only. The active compare values are reloaded from the buffers at a point chosen by a transfer-mode input: at the counter crest, at the trough, at both, or never while running. The period and dead-time values are taken into use only while the counter is stopped. The counter runs up from the dead-time value to the period value and back down. A polarity-invert input flips all six outputs after dead-time insertion.

Top module: `dtpwm_core`

## Requirements
- R1: While reset is asserted, all six outputs are low.
- R2: With polarity invert low, the positive and negative outputs of a phase are never high in the same cycle.
- R3: While running, the counter sweeps between the dead-time value L and the period value P, so the output pattern repeats every 2*(P-L) clocks.
- R4: For a duty d with L < d < P and a dead time D, the positive output is high for 2*(P-d)-1-D clocks per cycle and the negative output is high for 2*(d-L)+1-D clocks.
- R5: With dead-time insertion enabled, exactly D clocks with both outputs low separate a positive fall from the next negative rise, and a negative fall from the next positive rise.
- R6: With dead-time insertion disabled, one output rises in the same cycle the other falls, and the widths of R4 hold with D = 0. The counter still starts from L.
- R7: Writes at addresses 0, 1 and 2 set the duty buffers of phases 0, 1 and 2. Under transfer mode 0 a running unit never changes its active duty. Stopping the unit (run low) loads the buffers.
- R8: Transfer mode 1 reloads the active duty at the crest. A pulse that is in progress when a new duty is written has width (P-old)+(P-1-new)-D, and the next pulse uses the new duty.
- R9: Transfer mode 2 reloads the active duty only at the trough. The pulse in progress keeps the old duty and the next pulse uses the new one.
- R10: Transfer mode 3 reloads the active duty at both the crest and the trough.
- R11: A duty of 0 holds the positive output high and the negative output low. A duty at or above P holds the positive output low and the negative output high. Neither case produces any dead-time gap.
- R12: Writes to the period (address 3) and dead-time (address 4) registers take effect only after the unit has been stopped.
- R13: Polarity invert high inverts all six outputs. A running phase then shows 2*D cycles per period in which both outputs are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Counter runs when high; when low the counter rests and configuration is loaded |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0-2 duty buffer of phase, 3 period, 4 dead time |
| wr_data | input | CNT_W | Write data |
| xfer_mode | input | 2 | Duty reload point: 0 none, 1 crest, 2 trough, 3 both |
| dt_en | input | 1 | Dead-time insertion enable |
| pol_inv | input | 1 | Inverts all outputs after dead-time insertion |
| pwm_p | output | PHASES | Positive outputs, one per phase |
| pwm_n | output | PHASES | Negative outputs, one per phase |

## Verification
The hardest case to reach is a buffer write that lands in the middle of an output pulse, before the crest. Only then do the crest and trough reload modes give different pulse widths. The bench waits for the positive output of phase 0 to rise and writes the new duty in the next clock. It then measures the width of that pulse and of the following pulse under each of the four modes. The configuration latch is tested the same way: new period and dead-time values are written while the unit runs, the gap and period are shown to be unchanged, and then the unit is restarted.

// File: rtl/dtpwm_pkg.sv
package dtpwm_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    XFER_NONE   = 2'd0,
    XFER_CREST  = 2'd1,
    XFER_TROUGH = 2'd2,
    XFER_BOTH   = 2'd3
  } xfer_e;

  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_DEAD   = 3'd4;
endpackage

// File: rtl/dtpwm_tricnt.sv
module dtpwm_tricnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] lo,
  input  logic [CNT_W-1:0] hi,
  input  logic [CNT_W-1:0] lo_load,
  output logic [CNT_W-1:0] cnt,
  output logic             crest,
  output logic             trough
);
  logic up;

  assign crest  = run && up && (cnt >= hi);
  assign trough = run && !up && (cnt <= lo);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (!run) begin
      cnt <= lo_load;
      up  <= 1'b1;
    end else if (up) begin
      if (cnt >= hi) begin
        up  <= 1'b0;
        cnt <= (cnt > lo) ? cnt - CNT_W'(1) : cnt;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end else begin
      if (cnt <= lo) begin
        up  <= 1'b1;
        cnt <= (cnt < hi) ? cnt + CNT_W'(1) : cnt;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  // R3: the counter stays inside the sweep window while the window is valid
  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
    (hi > lo) |-> (cnt >= lo && cnt <= hi));
endmodule

// File: rtl/dtpwm_regs.sv
module dtpwm_regs
  import dtpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DT_W   = 16,
  parameter int PHASES = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          run,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [CNT_W-1:0]              wr_data,
  input  logic [1:0]                    mode,
  input  logic                          crest,
  input  logic                          trough,
  output logic [PHASES-1:0][CNT_W-1:0]  duty_act,
  output logic [CNT_W-1:0]              per_act,
  output logic [DT_W-1:0]               dt_act,
  output logic [DT_W-1:0]               dt_buf
);
  xfer_e                      xmode;
  logic                       xfer;
  logic [CNT_W-1:0]           per_buf;
  logic [PHASES-1:0][CNT_W-1:0] duty_buf;

  assign xmode = xfer_e'(mode);

  always_comb begin
    case (xmode)
      XFER_CREST:  xfer = crest;
      XFER_TROUGH: xfer = trough;
      XFER_BOTH:   xfer = crest | trough;
      default:     xfer = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_buf <= '0;
      dt_buf  <= '0;
      per_act <= '0;
      dt_act  <= '0;
    end else begin
      if (wr_en && wr_addr == ADDR_PERIOD) per_buf <= wr_data;
      if (wr_en && wr_addr == ADDR_DEAD)   dt_buf  <= wr_data[DT_W-1:0];
      if (!run) begin
        per_act <= per_buf;
        dt_act  <= dt_buf;
      end
    end
  end

  for (genvar g = 0; g < PHASES; g++) begin : g_duty
    always_ff @(posedge clk) begin
      if (rst) begin
        duty_buf[g] <= '0;
        duty_act[g] <= '0;
      end else begin
        if (wr_en && wr_addr == ADDR_W'(g)) duty_buf[g] <= wr_data;
        if (!run || xfer) duty_act[g] <= duty_buf[g];
      end
    end
  end

  // R7: a running unit keeps its active duty when no reload point is selected
  assert_duty_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (run && (mode == 2'd0 || (!crest && !trough))) |=> $stable(duty_act));

  // R12: period and dead time stay fixed while running
  assert_cfg_hold_R12: assert property (@(posedge clk) disable iff (rst)
    run |=> ($stable(per_act) && $stable(dt_act)));
endmodule

// File: rtl/dtpwm_phase.sv
module dtpwm_phase #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty,
  input  logic [CNT_W-1:0] per,
  input  logic [DT_W-1:0]  dead,
  input  logic             pol,
  output logic             out_p,
  output logic             out_n
);
  logic            raw_nx, raw_q, raw_d;
  logic [DT_W-1:0] tmr, tmr_nx;
  logic            p_dt, n_dt;

  always_comb begin
    if (duty == '0)        raw_nx = 1'b1;
    else if (duty >= per)  raw_nx = 1'b0;
    else                   raw_nx = (cnt > duty);
  end

  always_comb begin
    if (raw_q != raw_d)    tmr_nx = dead;
    else if (tmr != '0)    tmr_nx = tmr - DT_W'(1);
    else                   tmr_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= 1'b0;
      raw_d <= 1'b0;
      tmr   <= '0;
      p_dt  <= 1'b0;
      n_dt  <= 1'b0;
      out_p <= 1'b0;
      out_n <= 1'b0;
    end else begin
      raw_q <= raw_nx;
      raw_d <= raw_q;
      tmr   <= tmr_nx;
      p_dt  <= raw_q && (tmr_nx == '0);
      n_dt  <= !raw_q && (tmr_nx == '0);
      out_p <= p_dt ^ pol;
      out_n <= n_dt ^ pol;
    end
  end

  // R5: with a nonzero dead time, a positive rise follows a cycle with the negative side off
  assert_gap_pos_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(dead) != '0 && $rose(p_dt)) |-> $past(!n_dt));

  // R5: the same holds for a negative rise
  assert_gap_neg_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(dead) != '0 && $rose(n_dt)) |-> $past(!p_dt));
endmodule

// File: rtl/dtpwm_core.sv
module dtpwm_core
  import dtpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DT_W   = 16,
  parameter int PHASES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [1:0]        xfer_mode,
  input  logic              dt_en,
  input  logic              pol_inv,
  output logic [PHASES-1:0] pwm_p,
  output logic [PHASES-1:0] pwm_n
);
  logic [PHASES-1:0][CNT_W-1:0] duty_act;
  logic [CNT_W-1:0]             per_act;
  logic [DT_W-1:0]              dt_act, dt_buf, dead_eff;
  logic [CNT_W-1:0]             cnt, lo, lo_load;
  logic                         crest, trough;

  assign lo       = CNT_W'(dt_act);
  assign lo_load  = CNT_W'(dt_buf);
  assign dead_eff = dt_en ? dt_act : '0;

  dtpwm_regs #(.CNT_W(CNT_W), .DT_W(DT_W), .PHASES(PHASES)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .mode     (xfer_mode),
    .crest    (crest),
    .trough   (trough),
    .duty_act (duty_act),
    .per_act  (per_act),
    .dt_act   (dt_act),
    .dt_buf   (dt_buf)
  );

  dtpwm_tricnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .lo      (lo),
    .hi      (per_act),
    .lo_load (lo_load),
    .cnt     (cnt),
    .crest   (crest),
    .trough  (trough)
  );

  for (genvar g = 0; g < PHASES; g++) begin : g_phase
    dtpwm_phase #(.CNT_W(CNT_W), .DT_W(DT_W)) u_ph (
      .clk   (clk),
      .rst   (rst),
      .cnt   (cnt),
      .duty  (duty_act[g]),
      .per   (per_act),
      .dead  (dead_eff),
      .pol   (pol_inv),
      .out_p (pwm_p[g]),
      .out_n (pwm_n[g])
    );
  end

  // R2: with polarity not inverted, no phase drives both switches at once
  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(pol_inv) |-> ((pwm_p & pwm_n) == '0));
endmodule

// File: tb/dtpwm_core_bench.sv
module dtpwm_core_bench;
  localparam int CNT_W = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [1:0] xfer_mode = 2'd0;
  logic       dt_en = 1'b0;
  logic       pol_inv = 1'b0;
  logic [2:0] pwm_p, pwm_n;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int overlap_cnt = 0;
  bit pol_prev = 1'b0;
  bit finished = 1'b0;

  dtpwm_core u_dtpwm_core (
    .clk(clk), .rst(rst), .run(run), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .xfer_mode(xfer_mode), .dt_en(dt_en),
    .pol_inv(pol_inv), .pwm_p(pwm_p), .pwm_n(pwm_n)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && !pol_inv && !pol_prev && ((pwm_p & pwm_n) != 3'b000)) overlap_cnt++;
    pol_prev = pol_inv;
  end

  function automatic int exp_pw(int p, int d, int dd);
    return 2 * (p - d) - 1 - dd;
  endfunction
  function automatic int exp_nw(int d, int l, int dd);
    return 2 * (d - l) + 1 - dd;
  endfunction
  function automatic int exp_per(int p, int l);
    return 2 * (p - l);
  endfunction
  function automatic int exp_mixed(int p, int o, int n, int dd);
    return (p - o) + (p - 1 - n) - dd;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic check_eq(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int v);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = v[CNT_W-1:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(int p, int dt, int d0, int d1, int d2, bit den, int m);
    run = 1'b0; dt_en = den; xfer_mode = m[1:0];
    @(negedge clk);
    wr(3, p); wr(4, dt); wr(0, d0); wr(1, d1); wr(2, d2);
    repeat (4) @(negedge clk);
    run = 1'b1;
  endtask

  task automatic wait_p_rise(int ph);
    while (pwm_p[ph] === 1'b1) @(negedge clk);
    while (pwm_p[ph] !== 1'b1) @(negedge clk);
  endtask

  task automatic measure(int ph, int p, int l, int d, int dd, string wtag, string gtag);
    int t0, w, g;
    wait_p_rise(ph);
    wait_p_rise(ph);
    t0 = cyc;
    w = 0; while (pwm_p[ph]) begin w++; @(negedge clk); end
    check_eq(wtag, w, exp_pw(p, d, dd));
    g = 0; while (!pwm_n[ph]) begin g++; @(negedge clk); end
    check_eq(gtag, g, dd);
    w = 0; while (pwm_n[ph]) begin w++; @(negedge clk); end
    check_eq(wtag, w, exp_nw(d, l, dd));
    g = 0; while (!pwm_p[ph]) begin g++; @(negedge clk); end
    check_eq(gtag, g, dd);
    check_eq("R3", cyc - t0, exp_per(p, l));
  endtask

  task automatic mode_case(int m, int w1e, int w2e, string tag);
    int t0;
    setup(60, 3, 20, 30, 30, 1'b1, m);
    wait_p_rise(0); wait_p_rise(0);
    t0 = cyc;
    wr(0, 40);
    while (pwm_p[0]) @(negedge clk);
    check_eq(tag, cyc - t0, w1e);
    wait_p_rise(0);
    t0 = cyc;
    while (pwm_p[0]) @(negedge clk);
    check_eq(tag, cyc - t0, w2e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    // R1: reset state
    repeat (5) @(negedge clk);
    check_eq("R1", int'(pwm_p), 0);
    check_eq("R1", int'(pwm_n), 0);
    rst = 1'b0;

    // R4 R5: directed config, all phases
    setup(60, 3, 30, 15, 50, 1'b1, 1);
    measure(0, 60, 3, 30, 3, "R4", "R5");
    measure(1, 60, 3, 15, 3, "R4", "R5");
    measure(2, 60, 3, 50, 3, "R4", "R5");

    // R6: dead time disabled, counter still starts at the dead-time value
    setup(50, 5, 25, 10, 40, 1'b0, 1);
    for (int ph = 0; ph < 3; ph++) begin
      int d;
      d = (ph == 0) ? 25 : ((ph == 1) ? 10 : 40);
      measure(ph, 50, 5, d, 0, "R6", "R6");
    end

    // R3 R4 R5: random configurations
    for (int i = 0; i < 6; i++) begin
      int p, dt, dd, lo, hi;
      int dv [3];
      bit den;
      p = int'($urandom_range(40, 160));
      dt = int'($urandom_range(0, 8));
      den = 1'($urandom_range(0, 1));
      dd = den ? dt : 0;
      lo = dt + dd + 1;
      hi = p - dd - 1;
      for (int k = 0; k < 3; k++) dv[k] = int'($urandom_range(lo, hi));
      setup(p, dt, dv[0], dv[1], dv[2], den, int'($urandom_range(0, 3)));
      for (int k = 0; k < 3; k++)
        measure(k, p, dt, dv[k], dd, den ? "R4" : "R6", den ? "R5" : "R6");
    end

    // R7 R8 R9 R10: reload point for a write inside a pulse
    mode_case(0, exp_pw(60, 20, 3), exp_pw(60, 20, 3), "R7");
    run = 1'b0; repeat (4) @(negedge clk); run = 1'b1;
    wait_p_rise(0); wait_p_rise(0);
    begin
      int t0;
      t0 = cyc;
      while (pwm_p[0]) @(negedge clk);
      check_eq("R7", cyc - t0, exp_pw(60, 40, 3));
    end
    mode_case(1, exp_mixed(60, 20, 40, 3), exp_pw(60, 40, 3), "R8");
    mode_case(2, exp_pw(60, 20, 3), exp_pw(60, 40, 3), "R9");
    mode_case(3, exp_mixed(60, 20, 40, 3), exp_pw(60, 40, 3), "R10");

    // R12: period and dead time written while running take effect only after a stop
    setup(60, 3, 30, 30, 30, 1'b1, 1);
    measure(0, 60, 3, 30, 3, "R12", "R12");
    wr(4, 6); wr(3, 80);
    measure(0, 60, 3, 30, 3, "R12", "R12");
    run = 1'b0; repeat (4) @(negedge clk); run = 1'b1;
    measure(0, 80, 6, 30, 6, "R12", "R12");

    // R11: fixed levels
    setup(60, 3, 0, 60, 65, 1'b1, 1);
    repeat (300) @(negedge clk);
    begin
      int e0, e1, e2;
      e0 = 0; e1 = 0; e2 = 0;
      for (int c = 0; c < 2 * exp_per(60, 3); c++) begin
        if (!(pwm_p[0] && !pwm_n[0])) e0++;
        if (!(!pwm_p[1] && pwm_n[1])) e1++;
        if (!(!pwm_p[2] && pwm_n[2])) e2++;
        @(negedge clk);
      end
      check_eq("R11", e0, 0);
      check_eq("R11", e1, 0);
      check_eq("R11", e2, 0);
    end

    // R13: polarity invert on fixed levels
    pol_inv = 1'b1;
    repeat (5) @(negedge clk);
    check_eq("R13", int'(pwm_p), 3'b110);
    check_eq("R13", int'(pwm_n), 3'b001);

    // R13: inverted running phase shows both high during each dead-time gap
    setup(60, 3, 30, 30, 30, 1'b1, 1);
    repeat (300) @(negedge clk);
    begin
      int both;
      both = 0;
      for (int c = 0; c < exp_per(60, 3); c++) begin
        if (pwm_p[0] && pwm_n[0]) both++;
        @(negedge clk);
      end
      check_eq("R13", both, 2 * 3);
    end
    pol_inv = 1'b0;
    repeat (5) @(negedge clk);

    // R2: no overlap seen anywhere with polarity normal
    check_eq("R2", overlap_cnt, 0);
    summary();
  end
endmodule